// File: doc/BRIEF.md
# Collision-Free Transfer Slot Scheduler

This block decides where and when a set of readout sources delivers its event fragments into a farm of compute nodes arranged as a grid of `ROWS` rows and `COLS` columns. The number of sources equals `ROWS`. Each trigger is one pending event. When an event is started, the scheduler assigns it a node and runs it through `ROWS` transfer slots. In every slot, each source is told which receiver to write to. The receivers of one slot are all different, so no receiver ever has two senders at the same time.

Node assignment walks the grid in row-major order and skips nodes that the exclude mask marks as overloaded. Triggers that arrive while an event is in progress wait in a small pending queue. A trigger that finds the queue full raises an overflow pulse. Each slot ends only after every source has reported that it is done with that slot.

Top module: `xfer_slot_sched`

## Requirements
- R1: After reset, `busy_o`, `send_en_o`, `ovf_o` and `evt_node_o` are all zero, and the first event is assigned starting the search from node 0.
- R2: Each accepted trigger adds one pending event, up to `QDEPTH` pending events. `busy_o` is high whenever an event is active, any event is pending, or every bit of `excl_i` is set.
- R3: A trigger that arrives while `QDEPTH` events are pending is dropped. It raises `ovf_o` for exactly one cycle, the cycle after the trigger. This holds even if a queued event is started in the same cycle.
- R4: Node index is `row*COLS + col`. An event is given the first node whose `excl_i` bit is clear, searching upward from the node after the previously assigned one and wrapping at `ROWS*COLS`. The mask used is the one present in the cycle the event starts.
- R5: With no exclusions, node k is assigned again only after `ROWS*COLS` events.
- R6: While every `excl_i` bit is set, no event starts, and triggers are dropped without raising `ovf_o`.
- R7: An active event lasts `ROWS` slots. `send_en_o[i]` is high during a slot until source i has shown its `slot_done_i[i]` bit. The slot advances in the cycle after the last outstanding done bit arrives. Done bits may arrive over several cycles. Done bits are ignored while no event is active.
- R8: In slot s (counted from 0), source i is sent to node `((i+s) mod ROWS)*COLS + (evt_node_o mod COLS)`. This is field i of `dst_id_o`, at bits `[i*NODE_W +: NODE_W]`. All enabled sources therefore have distinct destinations.
- R9: An event starts one cycle after a pending event becomes visible in the queue. A trigger at clock edge k makes `send_en_o` rise after edge k+1 when the block is idle. A new event starts no earlier than the edge after the previous event ends.
- R10: `evt_node_o` holds the node of the most recently started event until the next event starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | One trigger per cycle in which it is high |
| slot_done_i | input | ROWS | Per-source report that its transfer for the current slot is finished |
| excl_i | input | ROWS*COLS | Set bit n to keep node n out of assignment |
| dst_id_o | output | ROWS*NODE_W | Per-source receiver node index, field i for source i |
| send_en_o | output | ROWS | Per-source permission to transmit |
| evt_node_o | output | NODE_W | Node assigned to the current or most recent event |
| busy_o | output | 1 | Work active or pending, or no node available |
| ovf_o | output | 1 | One-cycle pulse after a trigger dropped on a full queue |

## Verification
Two events can land on the same edge: a new trigger arriving, and a queued event being removed because the previous event has just finished its final slot. The bench provokes this by holding the queue full while it releases done bits, and it keeps the trigger rate high during random phases. The reference model in the bench judges the outcome. When the queue was full, the new trigger must be dropped with an overflow pulse even though an entry leaves in the same cycle. Otherwise the pending count must stay level, with one entry in and one out.

// File: rtl/xfer_sched_pkg.sv
package xfer_sched_pkg;
   // Adds two indices that are each below m, and wraps the sum into [0, m).
   function automatic int wrap_add(input int a, input int b, input int m);
      int s;
      s = a + b;
      if (s >= m) s = s - m;
      return s;
   endfunction
endpackage

// File: rtl/xfer_trig_queue.sv
module xfer_trig_queue #(
   parameter int QDEPTH = 4,
   localparam int CNT_W = $clog2(QDEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic block,
   input  logic take,
   output logic pend_nz,
   output logic ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic full, accept;

   assign full   = (cnt_q == CNT_W'(QDEPTH));
   assign accept = trig && !block && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf   <= 1'b0;
      end else begin
         ovf <= trig && !block && full;
         if (accept && !take)      cnt_q <= cnt_q + 1'b1;
         else if (!accept && take) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pend_nz = (cnt_q != '0);
endmodule

// File: rtl/xfer_node_picker.sv
module xfer_node_picker
   import xfer_sched_pkg::*;
#(
   parameter int NODES  = 12,
   parameter int NODE_W = 4
) (
   input  logic [NODE_W-1:0] ptr,
   input  logic [NODES-1:0]  excl,
   output logic [NODE_W-1:0] pick,
   output logic              none
);
   int idx;

   // Scan downward so that the lowest offset from ptr wins.
   always_comb begin
      pick = '0;
      idx  = 0;
      for (int k = NODES - 1; k >= 0; k--) begin
         idx = wrap_add(int'(ptr), k, NODES);
         if (!excl[idx]) pick = NODE_W'(idx);
      end
   end

   assign none = &excl;
endmodule

// File: rtl/xfer_slot_seq.sv
module xfer_slot_seq #(
   parameter int ROWS = 3,
   localparam int SLOT_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ROWS-1:0]   done,
   output logic              active,
   output logic [SLOT_W-1:0] slot,
   output logic [ROWS-1:0]   got
);
   logic [ROWS-1:0] seen;

   assign seen = got | done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= '0;
         got    <= '0;
      end else if (start) begin
         active <= 1'b1;
         slot   <= '0;
         got    <= '0;
      end else if (active) begin
         if (&seen) begin
            got <= '0;
            if (slot == SLOT_W'(ROWS - 1)) active <= 1'b0;
            else                           slot   <= slot + 1'b1;
         end else begin
            got <= seen;
         end
      end
   end
endmodule

// File: rtl/xfer_slot_sched.sv
module xfer_slot_sched
   import xfer_sched_pkg::*;
#(
   parameter int ROWS   = 3,
   parameter int COLS   = 4,
   parameter int QDEPTH = 4,
   localparam int NODES  = ROWS * COLS,
   localparam int NODE_W = $clog2(NODES),
   localparam int SLOT_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trig_i,
   input  logic [ROWS-1:0]          slot_done_i,
   input  logic [NODES-1:0]         excl_i,
   output logic [ROWS*NODE_W-1:0]   dst_id_o,
   output logic [ROWS-1:0]          send_en_o,
   output logic [NODE_W-1:0]        evt_node_o,
   output logic                     busy_o,
   output logic                     ovf_o
);
   if (ROWS < 2) begin : g_bad_rows
      $error("xfer_slot_sched: ROWS must be at least 2");
   end
   if (COLS < 1) begin : g_bad_cols
      $error("xfer_slot_sched: COLS must be at least 1");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("xfer_slot_sched: QDEPTH must be at least 1");
   end

   logic              pend_nz, none, start, evt_active;
   logic [NODE_W-1:0] ptr_q, node_q, pick;
   logic [SLOT_W-1:0] slot;
   logic [ROWS-1:0]   got;

   assign start = !evt_active && pend_nz && !none;

   xfer_trig_queue #(.QDEPTH(QDEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .trig(trig_i), .block(none),
      .take(start), .pend_nz(pend_nz), .ovf(ovf_o));

   xfer_node_picker #(.NODES(NODES), .NODE_W(NODE_W)) u_pick (
      .ptr(ptr_q), .excl(excl_i), .pick(pick), .none(none));

   xfer_slot_seq #(.ROWS(ROWS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .done(slot_done_i),
      .active(evt_active), .slot(slot), .got(got));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         node_q <= '0;
      end else if (start) begin
         node_q <= pick;
         ptr_q  <= NODE_W'(wrap_add(int'(pick), 1, NODES));
      end
   end

   // Source i, slot s: row (i+s) mod ROWS of the event's column.
   for (genvar i = 0; i < ROWS; i++) begin : g_src
      int row;
      always_comb begin
         row = wrap_add(int'(slot), i, ROWS);
         dst_id_o[i*NODE_W +: NODE_W] = NODE_W'(row * COLS + int'(node_q) % COLS);
      end
      assign send_en_o[i] = evt_active && !got[i];
   end

   assign evt_node_o = node_q;
   assign busy_o     = evt_active || pend_nz || none;
endmodule

// File: rtl/xfer_slot_sched_chk.sv
module xfer_slot_sched_chk #(
   parameter int ROWS   = 3,
   parameter int NODES  = 12,
   parameter int NODE_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NODES-1:0]       excl_i,
   input logic [ROWS*NODE_W-1:0] dst_id_o,
   input logic [ROWS-1:0]        send_en_o,
   input logic [NODE_W-1:0]      evt_node_o,
   input logic                   busy_o,
   input logic                   ovf_o,
   input logic                   evt_active
);
   for (genvar i = 0; i < ROWS; i++) begin : g_a
      for (genvar j = i + 1; j < ROWS; j++) begin : g_b
         p_distinct_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (send_en_o[i] && send_en_o[j]) |->
            (dst_id_o[i*NODE_W +: NODE_W] != dst_id_o[j*NODE_W +: NODE_W]));
      end
   end

   p_ovf_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> busy_o);

   p_no_start_all_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(&excl_i) && !$past(evt_active)) |-> !evt_active);

   p_node_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_active) |-> ((($past(excl_i)) >> evt_node_o) & NODES'(1)) == '0);

   p_send_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|send_en_o) |-> busy_o);
endmodule

bind xfer_slot_sched xfer_slot_sched_chk #(
   .ROWS(ROWS), .NODES(NODES), .NODE_W(NODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .excl_i(excl_i), .dst_id_o(dst_id_o),
   .send_en_o(send_en_o), .evt_node_o(evt_node_o), .busy_o(busy_o),
   .ovf_o(ovf_o), .evt_active(evt_active));

// File: tb/xfer_slot_sched_test.sv
module xfer_slot_sched_test;
   localparam int ROWS = 3, COLS = 4, QDEPTH = 4;
   localparam int NODES = ROWS * COLS, NODE_W = $clog2(NODES);
   localparam int NCYC = 4000;

   logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
   logic [ROWS-1:0] done = '0;
   logic [NODES-1:0] excl = '0;
   logic [ROWS*NODE_W-1:0] dst;
   logic [ROWS-1:0] send_en;
   logic [NODE_W-1:0] evt_node;
   logic busy, ovf;

   int checks = 0, fails = 0;
   int m_pend, m_act, m_slot, m_got, m_ptr, m_node, m_ovf;
   int n_ovf = 0, n_allex = 0, n_starts = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   xfer_slot_sched #(.ROWS(ROWS), .COLS(COLS), .QDEPTH(QDEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .slot_done_i(done), .excl_i(excl),
      .dst_id_o(dst), .send_en_o(send_en), .evt_node_o(evt_node),
      .busy_o(busy), .ovf_o(ovf));

   function automatic int pick_node(input int ptr, input logic [NODES-1:0] ex);
      for (int k = 0; k < NODES; k++)
         if (!ex[(ptr + k) % NODES]) return (ptr + k) % NODES;
      return 0;
   endfunction

   function automatic int exp_dst(input int i, input int s, input int node);
      return ((i + s) % ROWS) * COLS + node % COLS;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R2 R6 busy", int'(busy), int'(m_act != 0 || m_pend != 0 || (&excl)));
      chk("R3 ovf", int'(ovf), m_ovf);
      chk("R4 R5 R10 evt_node", int'(evt_node), m_node);
      for (int i = 0; i < ROWS; i++) begin
         chk("R7 R9 send_en", int'(send_en[i]), (m_act != 0 && !m_got[i]) ? 1 : 0);
         if (m_act != 0)
            chk("R8 dst", int'(dst[i*NODE_W +: NODE_W]), exp_dst(i, m_slot, m_node));
      end
   endtask

   task automatic model_step();
      int allx, start, accept, seen;
      allx   = &excl;
      start  = (m_act == 0 && m_pend > 0 && !allx);
      accept = trig && !allx && m_pend < QDEPTH;
      m_ovf  = (trig && !allx && m_pend == QDEPTH) ? 1 : 0;
      if (m_ovf != 0) n_ovf++;
      if (trig && allx) n_allex++;
      m_pend = m_pend + accept - start;
      if (start) begin
         m_node = pick_node(m_ptr, excl);
         m_ptr  = (m_node + 1) % NODES;
         m_act = 1; m_slot = 0; m_got = 0;
         n_starts++;
      end else if (m_act != 0) begin
         seen = m_got | int'(done);
         if (seen == (1 << ROWS) - 1) begin
            m_got = 0;
            if (m_slot == ROWS - 1) m_act = 0;
            else m_slot++;
         end else m_got = seen;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [NODES-1:0] ex_hold;
      void'($urandom(32'd4242));
      m_pend = 0; m_act = 0; m_slot = 0; m_got = 0; m_ptr = 0; m_node = 0; m_ovf = 0;
      ex_hold = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset send_en", int'(send_en), 0);
      chk("R1 reset ovf", int'(ovf), 0);
      chk("R1 reset evt_node", int'(evt_node), 0);
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         compare();
         if (cyc < 20) begin
            // Directed: hold slots open and flood triggers to fill the queue (R3).
            trig = (cyc < 9); done = '0; excl = '0;
         end else if (cyc < 40) begin
            // Release slots while triggers keep coming: dequeue meets trigger.
            trig = (cyc % 2 == 0); done = '1; excl = '0;
         end else if (cyc < 80) begin
            // Every node excluded (R6).
            trig = ($urandom % 2 == 0); done = ROWS'($urandom); excl = '1;
         end else if (cyc < 140) begin
            // No exclusions, full-speed slots: node rotation (R5).
            trig = ($urandom % 3 == 0); done = '1; excl = '0;
         end else begin
            if (cyc % 150 == 0) begin
               case ($urandom % 4)
                  0: ex_hold = '0;
                  1: ex_hold = NODES'($urandom) & NODES'($urandom);
                  2: ex_hold = NODES'($urandom);
                  default: ex_hold = '1;
               endcase
            end
            excl = ex_hold;
            trig = ($urandom % 3 != 0);
            done = ROWS'($urandom);
         end
         model_step();
         @(negedge clk);
      end
      chk("R3 overflow provoked", int'(n_ovf > 0), 1);
      chk("R6 all-excluded triggers seen", int'(n_allex > 0), 1);
      chk("R5 wrap reached", int'(n_starts > NODES), 1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule